// File: doc/BRIEF.md
# Pipeline Register File with Same-Cycle Write Bypass

This block holds the general-purpose registers of a five-stage in-order pipeline. The decode stage reads two source operands through two combinational read ports. The writeback stage commits one result through a synchronous write port. The storage is built from rising-edge flip-flops, a write-address decoder and output multiplexers, so a read and a write can happen in the same cycle without a structural conflict or an undefined result.

A compile-time switch selects the behaviour when decode reads a register that writeback is writing in the same cycle.
- In write-through mode, each read port compares its own address with the write address and forwards the incoming data on a match. Decode therefore sees the new value in that cycle, as if the write had landed in the first half of the cycle.
- In stored-value mode, the port returns the older contents, and the new value becomes visible from the next cycle on.

Register zero is hardwired to zero in both modes.

Top module: `regfile_top`

## Requirements
- R1: An active-high synchronous reset clears every register, so after reset both read ports return 0 for every address.
- R2: When the write-enable input is high on a rising edge and the write address is nonzero, that register holds the write data from then on. Each read port returns the stored value of the register it addresses.
- R3: The write is discarded when the write-enable input is low on that edge, and the target register keeps its value.
- R4: Address 0 always reads as 0 on both ports. A write to address 0 is discarded and is never forwarded, even in the cycle in which it is presented.
- R5: With BYPASS_EN=1, a port whose address equals a nonzero write address while the write-enable input is high returns the write data in that same cycle.
- R6: With BYPASS_EN=0, a port in the R5 situation returns the previously stored value in that cycle, and the new value from the next cycle on.
- R7: The two read ports decide forwarding independently: a port whose address differs from the write address returns stored contents while the other port is forwarding.
- R8: With the write-enable input low, both outputs depend only on the stored contents and the read addresses, whatever the write address and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |

## Verification
The hardest case to reach is the moment inside a single cycle in which a write is presented but not yet committed while a read of the same register is being sampled. The bench therefore holds the inputs steady and samples the outputs before the rising edge. It repeats the same stimulus on two instances, one per mode, so that forwarded data and stale data are told apart in the same cycle. It also covers the case in which one port matches the write address and the other does not, and a write to address 0 presented together with reads of address 0.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    typedef enum logic {
        MODE_STORED = 1'b0,
        MODE_BYPASS = 1'b1
    } rf_mode_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [XLEN-1:0]      wr_data,
    output logic [NREGS*XLEN-1:0] regs_flat
);
    typedef struct packed {
        logic [NREGS-1:1][XLEN-1:0] r;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NREGS; i++) begin
            if (wr_en && (wr_addr == AW'(i))) st_d.r[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_flat
            if (g == 0) begin : g_zero
                assign regs_flat[XLEN-1:0] = '0;
            end else begin : g_reg
                assign regs_flat[g*XLEN +: XLEN] = st_q.r[g];
            end
        end
    endgenerate

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q == '0));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int       NREGS = 32,
    parameter int       XLEN  = 32,
    parameter rf_mode_e MODE  = MODE_BYPASS,
    localparam int      AW    = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREGS*XLEN-1:0] regs_flat,
    input  logic [AW-1:0]         rd_addr,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [XLEN-1:0]       wr_data,
    output logic [XLEN-1:0]       rd_data
);
    logic [XLEN-1:0] stored;
    logic            hit;

    assign stored = regs_flat[rd_addr*XLEN +: XLEN];
    assign hit    = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);

    generate
        if (MODE == MODE_BYPASS) begin : g_fwd
            assign rd_data = hit ? wr_data : stored;
        end else begin : g_old
            assign rd_data = stored;
        end
    endgenerate

    // R4
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0) |-> (rd_data == '0));
    // R2
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) ##1 (rd_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_addr))
        |-> (rd_data == $past(wr_data)));
    generate
        if (MODE == MODE_BYPASS) begin : g_fwd_chk
            // R5
            fwd_match_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == rd_addr && rd_addr != '0) |-> (rd_data == wr_data));
        end
    endgenerate
endmodule

// File: rtl/regfile_top.sv
module regfile_top
    import regfile_pkg::*;
#(
    parameter int NREGS     = 32,
    parameter int XLEN      = 32,
    parameter bit BYPASS_EN = 1'b1,
    localparam int AW       = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data
);
    localparam rf_mode_e MODE = BYPASS_EN ? MODE_BYPASS : MODE_STORED;

    logic [NREGS*XLEN-1:0] regs_flat;

    rf_storage #(.NREGS(NREGS), .XLEN(XLEN)) i_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    rf_read_port #(.NREGS(NREGS), .XLEN(XLEN), .MODE(MODE)) i_port_a (
        .clk(clk), .rst(rst), .regs_flat(regs_flat), .rd_addr(rd_addr_a),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data_a)
    );

    rf_read_port #(.NREGS(NREGS), .XLEN(XLEN), .MODE(MODE)) i_port_b (
        .clk(clk), .rst(rst), .regs_flat(regs_flat), .rd_addr(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data_b)
    );

    // R7
    same_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

// File: tb/test_regfile_top.sv
module test_regfile_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  ra, rb, wa;
    logic        we;
    logic [31:0] wd;
    logic [31:0] fa, fb, sa, sb;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    regfile_top #(.BYPASS_EN(1'b1)) i_regfile_top (
        .clk(clk), .rst(rst), .rd_addr_a(ra), .rd_data_a(fa), .rd_addr_b(rb),
        .rd_data_b(fb), .wr_en(we), .wr_addr(wa), .wr_data(wd));
    regfile_top #(.BYPASS_EN(1'b0)) i_regfile_top_old (
        .clk(clk), .rst(rst), .rd_addr_a(ra), .rd_data_a(sa), .rd_addr_b(rb),
        .rd_data_b(sb), .wr_en(we), .wr_addr(wa), .wr_data(wd));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; wa = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) begin
            ra = 5'(i); rb = 5'(31 - i); #1;
            chk("R1 port A", fa, 32'h0);
            chk("R1 port B", fb, 32'h0);
        end
    endtask

    task automatic t_write_read;
        for (int i = 1; i < 32; i++) wr(5'(i), 32'hA500_0000 + 32'(i * 3));
        for (int i = 1; i < 32; i++) begin
            ra = 5'(i); rb = 5'(32 - i); #1;
            chk("R2 port A", fa, 32'hA500_0000 + 32'(i * 3));
            chk("R2 port B", fb, 32'hA500_0000 + 32'((32 - i) * 3));
            chk("R2 stored mode", sa, 32'hA500_0000 + 32'(i * 3));
        end
    endtask

    task automatic t_no_enable;
        @(negedge clk); we = 1'b0; wa = 5'd7; wd = 32'hDEAD_BEEF;
        ra = 5'd7; rb = 5'd8; #1;
        chk("R8 port A", fa, 32'hA500_0000 + 32'd21);
        chk("R8 port B", fb, 32'hA500_0000 + 32'd24);
        @(negedge clk); ra = 5'd7; #1;
        chk("R3 discarded", fa, 32'hA500_0000 + 32'd21);
    endtask

    task automatic t_zero;
        @(negedge clk); we = 1'b1; wa = 5'd0; wd = 32'hFFFF_FFFF; ra = 5'd0; rb = 5'd0; #1;
        chk("R4 no forward A", fa, 32'h0);
        chk("R4 no forward B", fb, 32'h0);
        @(negedge clk); we = 1'b0; #1;
        chk("R4 write dropped", fa, 32'h0);
        chk("R4 stored mode", sa, 32'h0);
    endtask

    task automatic t_bypass;
        @(negedge clk); we = 1'b1; wa = 5'd12; wd = 32'h1234_5678; ra = 5'd12; rb = 5'd13; #1;
        chk("R5 forward A", fa, 32'h1234_5678);
        chk("R7 other port stored", fb, 32'hA500_0000 + 32'd39);
        chk("R6 old value A", sa, 32'hA500_0000 + 32'd36);
        chk("R7 stored-mode port B", sb, 32'hA500_0000 + 32'd39);
        @(negedge clk); we = 1'b0; #1;
        chk("R6 new value next cycle", sa, 32'h1234_5678);
        chk("R5 committed", fa, 32'h1234_5678);
        @(negedge clk); we = 1'b1; wa = 5'd20; wd = 32'h0BAD_F00D; ra = 5'd3; rb = 5'd20; #1;
        chk("R5 forward B", fb, 32'h0BAD_F00D);
        chk("R7 port A unaffected", fa, 32'hA500_0000 + 32'd9);
        chk("R6 old value B", sb, 32'hA500_0000 + 32'd60);
        @(negedge clk); we = 1'b0;
    endtask

    initial begin
        rst = 1'b1; we = 1'b0; wa = '0; wd = '0; ra = '0; rb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_no_enable();
        t_zero();
        t_bypass();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule